// File: doc/BRIEF.md
# Carry-Feedback Serial-Parallel Multiplier

This block multiplies two unsigned N-bit numbers. The multiplier word is presented in parallel, and the multiplicand arrives one bit per clock, least significant bit first. Each of the N identical slices forms the AND of its stored multiplier bit and the current multiplicand bit. It adds that bit to the registered sum coming from the next-higher slice and to its own carry, which a one-cycle register returns to the same slice. The lowest slice delivers one product bit per clock, so the full 2N-bit product leaves serially, least significant bit first, over 2N cycles.

An operand window opens on a cycle with `start` high. The first multiplicand bit and the whole multiplier word are sampled in that cycle, and the next N-1 cycles bring the remaining multiplicand bits. The block supplies the N trailing zero bits itself, so the serial input is free during the second half of the window and between windows. A new window may open right after the previous one ends, which keeps the product stream gap-free.

Top module: `cdm_mult`

## Requirements
- R1: Each window yields 2N product bits on `serial_p`, least significant bit first, equal to the unsigned product of the multiplicand and the multiplier word.
- R2: The multiplicand bit k (k = 0..N-1) is taken from `serial_a` k cycles after the `start` cycle. The multiplier word is taken from `b` only in the `start` cycle, and later changes of `b` have no effect on that product.
- R3: `serial_a` is ignored in window cycles N..2N-1 and in every cycle outside a window.
- R4: `p_valid` is high for exactly 2N consecutive cycles per window. The first product bit is present after the second rising edge that follows the `start` cycle; the rising edge that samples `start` is the first.
- R5: Every slice carry is cleared when a window opens, so a product does not depend on earlier traffic, including a window that opens directly after the previous one.
- R6: `serial_p` is low in every cycle in which `p_valid` is low.
- R7: A synchronous active-high `rst` drives `p_valid` and `serial_p` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens an operand window in this cycle |
| serial_a | input | 1 | Multiplicand bit stream, LSB first |
| b | input | N | Multiplier word, sampled in the `start` cycle |
| serial_p | output | 1 | Product bit stream, LSB first |
| p_valid | output | 1 | High while `serial_p` carries a product bit |

## Verification
On every cycle, assertions check four things: a window opening leaves every slice carry at zero, padding-phase input bits never reach the slices, `p_valid` appears two edges after `start`, and `serial_p` is quiet outside valid cycles. The arithmetic itself, the exact window length and the independence from changes on `b` can only be shown by the bench's scenarios. These deserialise each product and compare it with the integer product for the operand extremes 0, 1 and all-ones, for random operands, and for back-to-back windows with random junk on the idle inputs.

// File: rtl/cdm_pkg.sv
package cdm_pkg;

  // One-bit full add: returns {carry, sum}
  function automatic logic [1:0] fadd(input logic x, input logic y, input logic z);
    return {1'b0, x} + {1'b0, y} + {1'b0, z};
  endfunction

endpackage

// File: rtl/cdm_ctrl.sv
module cdm_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         serial_a,
  input  logic [N-1:0] b,
  output logic         a_q,
  output logic [N-1:0] b_hold,
  output logic         clr_q,
  output logic         win_q
);
  localparam int WIN = 2 * N;
  localparam int CW  = $clog2(WIN + 1);
  localparam logic [CW-1:0] NL   = CW'(N);
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [CW-1:0] idx;
  logic          active;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      active <= 1'b0;
      a_q    <= 1'b0;
      b_hold <= '0;
      clr_q  <= 1'b0;
      win_q  <= 1'b0;
    end else begin
      clr_q <= start;
      win_q <= start | active;
      if (start) begin
        b_hold <= b;
        a_q    <= serial_a;
        idx    <= CW'(1);
        active <= 1'b1;
      end else if (active) begin
        a_q <= (idx < NL) ? serial_a : 1'b0;
        if (idx == LAST) begin
          idx    <= '0;
          active <= 1'b0;
        end else begin
          idx <= idx + CW'(1);
        end
      end else begin
        a_q <= 1'b0;
      end
    end
  end

  // R3: padding-phase input never reaches the slices
  assert_pad_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (active && !start && idx >= NL) |=> (a_q == 1'b0));

endmodule

// File: rtl/cdm_slice.sv
module cdm_slice
  import cdm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic a_bit,
  input  logic b_bit,
  input  logic sum_in,
  output logic sum_q
);
  logic       carry_q;
  logic       s_add, c_add;
  logic [1:0] res;

  always_comb begin
    s_add = clr ? 1'b0 : sum_in;
    c_add = clr ? 1'b0 : carry_q;
    res   = fadd(a_bit & b_bit, s_add, c_add);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      sum_q   <= 1'b0;
    end else begin
      carry_q <= res[1];
      sum_q   <= res[0];
    end
  end

  // R5: opening a window leaves no carry behind
  assert_carry_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (carry_q == 1'b0));

endmodule

// File: rtl/cdm_mult.sv
module cdm_mult #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         serial_a,
  input  logic [N-1:0] b,
  output logic         serial_p,
  output logic         p_valid
);
  logic         a_q, clr_q, win_q;
  logic [N-1:0] b_hold;
  logic [N:0]   sum_chain;

  cdm_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .serial_a (serial_a),
    .b        (b),
    .a_q      (a_q),
    .b_hold   (b_hold),
    .clr_q    (clr_q),
    .win_q    (win_q)
  );

  assign sum_chain[N] = 1'b0;

  for (genvar j = 0; j < N; j++) begin : g_slice
    cdm_slice u_slice (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr_q),
      .a_bit  (a_q),
      .b_bit  (b_hold[j]),
      .sum_in (sum_chain[j+1]),
      .sum_q  (sum_chain[j])
    );
  end

  assign serial_p = sum_chain[0];

  always_ff @(posedge clk) begin
    if (rst) p_valid <= 1'b0;
    else     p_valid <= win_q;
  end

  // R4: first product bit two edges after start
  assert_first_bit_latency_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> ##1 p_valid);

  // R6: quiet output between windows
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !p_valid |-> !serial_p);

endmodule

// File: tb/test_cdm_mult.sv
`timescale 1ns/1ps
module test_cdm_mult;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst, start, serial_a;
  logic [N-1:0] b;
  logic         serial_p, p_valid;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  logic [W-1:0] exp_q[$];
  int           first_q[$];

  cdm_mult #(.N(N)) i_cdm_mult (
    .clk(clk), .rst(rst), .start(start), .serial_a(serial_a),
    .b(b), .serial_p(serial_p), .p_valid(p_valid)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Driver: one operand window plus an idle gap
  task automatic run_op(input logic [N-1:0] av, input logic [N-1:0] bv,
                        input bit junk, input int gap);
    @(negedge clk);
    start = 1'b1; serial_a = av[0]; b = bv;
    exp_q.push_back(W'(av) * W'(bv));
    first_q.push_back(cyc + 2);
    for (int k = 1; k < W; k++) begin
      @(negedge clk);
      start = 1'b0;
      serial_a = (k < N) ? av[k] : (junk ? 1'($urandom_range(0, 1)) : 1'b0);
      if (junk) b = N'($urandom);   // R2: must not affect this product
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      start = 1'b0;
      serial_a = junk ? 1'b1 : 1'b0; // R3: ignored outside a window
      if (junk) b = N'($urandom);
    end
  endtask

  // Monitor: deserialise and compare against the scoreboard
  logic [W-1:0] acc;
  int           nb = 0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (p_valid) begin
        if (nb == 0) begin
          if (first_q.size() == 0)
            check(1'b0, "R4", "unexpected window", 64'd1, 64'd0);
          else begin
            int f;
            f = first_q.pop_front();
            check(cyc == f, "R4", "first bit cycle", 64'(cyc), 64'(f));
          end
        end
        acc[nb] = serial_p;
        nb++;
        if (nb == W) begin
          if (exp_q.size() == 0)
            check(1'b0, "R1", "product without operand", 64'(acc), 64'd0);
          else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            check(acc == e, "R1", "product", 64'(acc), 64'(e));
          end
          nb = 0;
        end
      end else begin
        check(nb == 0, "R4", "window length", 64'(nb), 64'd0);
        nb = 0;
        check(!serial_p, "R6", "idle output", 64'(serial_p), 64'd0);
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(1'b0, "WDOG", "watchdog expired", 64'd1, 64'd0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [N-1:0] ones;
    ones = '1;
    rst = 1'b1; start = 1'b0; serial_a = 1'b1; b = '1;
    repeat (3) @(negedge clk);
    check(p_valid == 1'b0, "R7", "reset p_valid", 64'(p_valid), 64'd0);
    check(serial_p == 1'b0, "R7", "reset serial_p", 64'(serial_p), 64'd0);
    rst = 1'b0; serial_a = 1'b0;

    // Extremes, back to back (R5), junk on idle inputs (R2, R3)
    run_op('0, '0, 1'b1, 0);
    run_op(N'(1), N'(1), 1'b1, 0);
    run_op(ones, ones, 1'b1, 0);
    run_op(N'(1), ones, 1'b1, 0);   // follows a max product directly
    run_op(ones, N'(1), 1'b0, 2);
    run_op('0, ones, 1'b1, 1);
    run_op(ones, '0, 1'b1, 3);
    run_op(ones, ones, 1'b0, 0);
    run_op(N'(1), N'(1), 1'b1, 0);

    for (int r = 0; r < 40; r++)
      run_op(N'($urandom), N'($urandom), 1'($urandom_range(0, 1)),
             $urandom_range(0, 3));

    @(negedge clk);
    start = 1'b0; serial_a = 1'b0;
    repeat (W + 4) @(negedge clk);
    check(exp_q.size() == 0, "R1", "products outstanding", 64'(exp_q.size()), 64'd0);
    check(first_q.size() == 0, "R4", "windows outstanding", 64'(first_q.size()), 64'd0);
    done = 1;
    summary();
    $finish;
  end
endmodule